// File: doc/BRIEF.md
# Dual-Channel Pixel Merger

A line sensor splits its pixels between two analog channels: one carries the odd-numbered pixels and the other the even-numbered ones. Both channels are digitized at the same moment. This block takes the two digitized streams and puts them back into one stream in ascending pixel order. Each pixel leaves the block with a two-bit region tag that says where on the sensor it lies: leading dummy, optical black, invalid or active. The last pixel of every line also carries a flag.

Each accepted pair is held for two cycles. The odd sample leaves first and the even sample leaves second. A new pair may therefore arrive at most once every two cycles. A pair that comes too early is dropped, and a sticky error flag records the loss. A line-start pulse sets pixel numbering back to 1.

The region spans are parameters. By default there are 34 dummy pixels, 96 optical-black pixels, 6 invalid pixels, 7400 active pixels and 6 more invalid pixels, which gives 7542 pixels per line.

Top module: `ccd_pair_merger`

## Requirements
- R1: While reset is low, and in the first cycle after it, `pix_valid_o` and `pix_ovf_o` are 0.
- R2: A pair is accepted at a clock edge where `odd_valid_i` and `even_valid_i` are both 1. In the next cycle `pix_valid_o` is 1 and `pix_data_o` holds the odd sample. In the cycle after that, it holds the even sample.
- R3: A strobe on only one channel is ignored: it produces no output pixel.
- R4: The first pixel sent out after reset is pixel 1. Each pixel sent out raises the number by one.
- R5: `pix_tag_o` classifies the current pixel number. Encoding: 0 = dummy (1..DUMMY_CNT), 1 = optical black (the next OB_CNT pixels), 2 = invalid (the next GAP_CNT pixels, and every pixel after the active span), 3 = active (the next VALID_CNT pixels). While `pix_valid_o` is 0, the tag is 0.
- R6: `pix_last_o` is 1 only on the pixel numbered LINE_LEN. LINE_LEN is the sum of all five spans. The pixel after it is numbered 1.
- R7: A pair presented while the odd sample of the previous pair is still being sent out is dropped, and `pix_ovf_o` goes to 1. It stays at 1 until reset.
- R8: Pairs that arrive every second cycle come out as an unbroken pixel stream and do not set `pix_ovf_o`.
- R9: A `line_start_i` pulse makes the next pixel sent out pixel 1. This holds even if a pixel is being sent out in the same cycle, and that pixel keeps its old number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start_i | input | 1 | Restart pixel numbering at 1 |
| odd_valid_i | input | 1 | Odd-channel sample strobe |
| odd_data_i | input | DATA_W | Odd-channel sample |
| even_valid_i | input | 1 | Even-channel sample strobe |
| even_data_i | input | DATA_W | Even-channel sample |
| pix_valid_o | output | 1 | Output pixel present |
| pix_data_o | output | DATA_W | Output pixel sample |
| pix_tag_o | output | 2 | Region tag of the output pixel |
| pix_last_o | output | 1 | Output pixel is the last of its line |
| pix_ovf_o | output | 1 | Sticky pair-loss flag |

## Verification
The bench builds the block with spans of 2 dummy, 4 black, 2 invalid, 6 active and 2 trailing pixels, which makes a 16-pixel line. DATA_W stays at 12. With a line that short, whole lines can be swept several times at both full and reduced pair rates. Every region boundary, the end-of-line wrap, a mid-line restart, a restart that coincides with an outgoing pixel, and the overflow case all occur within a few hundred cycles. Each pixel is compared with a number and tag computed in the bench.

// File: rtl/ccd_merge_pkg.sv
// Package: shared types for the dual-channel pixel merger.
// Assumes nothing beyond a two-bit region tag and a three-state pair phase.
package ccd_merge_pkg;

    // Region class of an output pixel; the encoding is visible at the port.
    typedef enum logic [1:0] {
        TAG_DUMMY   = 2'b00,
        TAG_BLACK   = 2'b01,
        TAG_INVALID = 2'b10,
        TAG_ACTIVE  = 2'b11
    } pix_tag_e;

    // Drain phase of the pair buffer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ODD  = 2'b01,
        PH_EVEN = 2'b10
    } pair_phase_e;

endpackage

// File: rtl/ccd_pair_buffer.sv
// Pair buffer: captures one odd/even sample pair and releases it as two
// pixels, odd first. Assumes both channel strobes are in phase; a strobe
// on only one channel is not a pair and is ignored. A pair that arrives
// while the odd sample is still pending is dropped and latches the flag.
module ccd_pair_buffer
    import ccd_merge_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odd_valid_i,
    input  logic [DATA_W-1:0] odd_data_i,
    input  logic              even_valid_i,
    input  logic [DATA_W-1:0] even_data_i,
    output logic              emit_o,
    output logic [DATA_W-1:0] emit_data_o,
    output logic              ovf_o
);

    pair_phase_e       phase_q;
    logic [DATA_W-1:0] odd_q;
    logic [DATA_W-1:0] even_q;
    logic              pair_in;

    // A pair exists only when both channels strobe together.
    always_comb begin
        pair_in = odd_valid_i && even_valid_i;
    end

    // Phase sequencing, sample capture and sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            odd_q   <= '0;
            even_q  <= '0;
            ovf_o   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (pair_in) begin
                        odd_q   <= odd_data_i;
                        even_q  <= even_data_i;
                        phase_q <= PH_ODD;
                    end
                end
                PH_ODD: begin
                    if (pair_in) begin
                        ovf_o <= 1'b1;
                    end
                    phase_q <= PH_EVEN;
                end
                PH_EVEN: begin
                    if (pair_in) begin
                        odd_q   <= odd_data_i;
                        even_q  <= even_data_i;
                        phase_q <= PH_ODD;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Output selection from the held pair.
    always_comb begin
        emit_o      = (phase_q != PH_IDLE);
        emit_data_o = (phase_q == PH_ODD) ? odd_q : even_q;
    end

endmodule

// File: rtl/ccd_pixel_counter.sv
// Pixel counter: holds the number of the next pixel to be sent out,
// 1-based. It wraps to 1 after LINE_LEN. A line-start pulse forces 1
// and takes priority over the advance in the same cycle.
module ccd_pixel_counter #(
    parameter int LINE_LEN = 7542,
    parameter int CNT_W    = $clog2(LINE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start_i,
    input  logic             advance_i,
    output logic [CNT_W-1:0] pix_num_o,
    output logic             at_last_o
);

    localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(LINE_LEN);

    // Detect the final position of the line.
    always_comb begin
        at_last_o = (pix_num_o == LAST);
    end

    // Advance, wrap and restart of the pixel number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_num_o <= FIRST;
        end else if (line_start_i) begin
            pix_num_o <= FIRST;
        end else if (advance_i) begin
            pix_num_o <= at_last_o ? FIRST : pix_num_o + FIRST;
        end
    end

endmodule

// File: rtl/ccd_region_classifier.sv
// Region classifier: maps a 1-based pixel number to its region tag.
// Assumes the spans follow in order dummy, black, invalid, active, and that
// everything after the active span is invalid.
module ccd_region_classifier
    import ccd_merge_pkg::*;
#(
    parameter int CNT_W     = 13,
    parameter int DUMMY_CNT = 34,
    parameter int OB_CNT    = 96,
    parameter int GAP_CNT   = 6,
    parameter int VALID_CNT = 7400
) (
    input  logic [CNT_W-1:0] pix_num_i,
    output pix_tag_e         tag_o
);

    localparam int END_DUMMY  = DUMMY_CNT;
    localparam int END_BLACK  = END_DUMMY + OB_CNT;
    localparam int END_LEAD   = END_BLACK + GAP_CNT;
    localparam int END_ACTIVE = END_LEAD + VALID_CNT;

    // Compare against the cumulative span boundaries.
    always_comb begin
        if (pix_num_i <= CNT_W'(END_DUMMY)) begin
            tag_o = TAG_DUMMY;
        end else if (pix_num_i <= CNT_W'(END_BLACK)) begin
            tag_o = TAG_BLACK;
        end else if (pix_num_i <= CNT_W'(END_LEAD)) begin
            tag_o = TAG_INVALID;
        end else if (pix_num_i <= CNT_W'(END_ACTIVE)) begin
            tag_o = TAG_ACTIVE;
        end else begin
            tag_o = TAG_INVALID;
        end
    end

endmodule

// File: rtl/ccd_pair_merger.sv
// Top: merges odd and even channel samples into one ascending pixel
// stream. Each pixel carries a region tag and an end-of-line flag.
// Assumes pairs arrive no more often than once every two cycles; an
// early pair is dropped and flagged.
module ccd_pair_merger
    import ccd_merge_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int DUMMY_CNT = 34,
    parameter int OB_CNT    = 96,
    parameter int GAP_CNT   = 6,
    parameter int VALID_CNT = 7400,
    parameter int TAIL_CNT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic              odd_valid_i,
    input  logic [DATA_W-1:0] odd_data_i,
    input  logic              even_valid_i,
    input  logic [DATA_W-1:0] even_data_i,
    output logic              pix_valid_o,
    output logic [DATA_W-1:0] pix_data_o,
    output logic [1:0]        pix_tag_o,
    output logic              pix_last_o,
    output logic              pix_ovf_o
);

    localparam int LINE_LEN = DUMMY_CNT + OB_CNT + GAP_CNT + VALID_CNT + TAIL_CNT;
    localparam int CNT_W    = $clog2(LINE_LEN + 1);

    logic              emit;
    logic [DATA_W-1:0] emit_data;
    logic [CNT_W-1:0]  pix_num;
    logic              at_last;
    pix_tag_e          region;

    ccd_pair_buffer #(
        .DATA_W (DATA_W)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .odd_valid_i  (odd_valid_i),
        .odd_data_i   (odd_data_i),
        .even_valid_i (even_valid_i),
        .even_data_i  (even_data_i),
        .emit_o       (emit),
        .emit_data_o  (emit_data),
        .ovf_o        (pix_ovf_o)
    );

    ccd_pixel_counter #(
        .LINE_LEN (LINE_LEN),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .advance_i    (emit),
        .pix_num_o    (pix_num),
        .at_last_o    (at_last)
    );

    ccd_region_classifier #(
        .CNT_W     (CNT_W),
        .DUMMY_CNT (DUMMY_CNT),
        .OB_CNT    (OB_CNT),
        .GAP_CNT   (GAP_CNT),
        .VALID_CNT (VALID_CNT)
    ) u_cls (
        .pix_num_i (pix_num),
        .tag_o     (region)
    );

    // Drive the output pixel; the tag and flag are gated by valid.
    always_comb begin
        pix_valid_o = emit;
        pix_data_o  = emit_data;
        pix_tag_o   = emit ? region : TAG_DUMMY;
        pix_last_o  = emit && at_last;
    end

endmodule

// File: rtl/ccd_pair_merger_chk.sv
// Checker: temporal properties of the merger, observed at its ports.
module ccd_pair_merger_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              odd_valid_i,
    input logic [DATA_W-1:0] odd_data_i,
    input logic              even_valid_i,
    input logic              pix_valid_o,
    input logic [DATA_W-1:0] pix_data_o,
    input logic              pix_last_o,
    input logic              pix_ovf_o
);

    // R2
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_valid_i && even_valid_i && !pix_valid_o)
        |=> (pix_valid_o && pix_data_o == $past(odd_data_i)));

    // R3
    lone_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((odd_valid_i != even_valid_i) && !pix_valid_o) |=> !pix_valid_o);

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last_o |-> pix_valid_o);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ovf_o |=> pix_ovf_o);

endmodule

bind ccd_pair_merger ccd_pair_merger_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .odd_valid_i  (odd_valid_i),
    .odd_data_i   (odd_data_i),
    .even_valid_i (even_valid_i),
    .pix_valid_o  (pix_valid_o),
    .pix_data_o   (pix_data_o),
    .pix_last_o   (pix_last_o),
    .pix_ovf_o    (pix_ovf_o)
);

// File: tb/ccd_pair_merger_bench.sv
module ccd_pair_merger_bench;

    localparam int DW   = 12;
    localparam int DUM  = 2;
    localparam int OB   = 4;
    localparam int GAP  = 2;
    localparam int ACT  = 6;
    localparam int TAIL = 2;
    localparam int LEN  = DUM + OB + GAP + ACT + TAIL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_start_i = 1'b0;
    logic          odd_valid_i = 1'b0;
    logic [DW-1:0] odd_data_i = '0;
    logic          even_valid_i = 1'b0;
    logic [DW-1:0] even_data_i = '0;
    logic          pix_valid_o;
    logic [DW-1:0] pix_data_o;
    logic [1:0]    pix_tag_o;
    logic          pix_last_o;
    logic          pix_ovf_o;

    int checks = 0;
    int errors = 0;
    int exp_num = 1;
    int seen = 0;
    int lasts = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    ccd_pair_merger #(
        .DATA_W (DW), .DUMMY_CNT (DUM), .OB_CNT (OB),
        .GAP_CNT (GAP), .VALID_CNT (ACT), .TAIL_CNT (TAIL)
    ) u_ccd_pair_merger (
        .clk (clk), .rst_n (rst_n), .line_start_i (line_start_i),
        .odd_valid_i (odd_valid_i), .odd_data_i (odd_data_i),
        .even_valid_i (even_valid_i), .even_data_i (even_data_i),
        .pix_valid_o (pix_valid_o), .pix_data_o (pix_data_o),
        .pix_tag_o (pix_tag_o), .pix_last_o (pix_last_o),
        .pix_ovf_o (pix_ovf_o)
    );

    function automatic int region_of(input int n);
        if (n <= DUM) return 0;
        if (n <= DUM + OB) return 1;
        if (n <= DUM + OB + GAP) return 2;
        if (n <= DUM + OB + GAP + ACT) return 3;
        return 2;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare each output pixel with the bench model, at negedge.
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_num = 1;
        end else begin
            if (pix_valid_o) begin
                int e;
                seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected pixel", int'(pix_data_o), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(pix_data_o == DW'(e), "R2", "pixel data", int'(pix_data_o), e);
                end
                check(int'(pix_tag_o) == region_of(exp_num), "R5", "region tag",
                      int'(pix_tag_o), region_of(exp_num));
                check(pix_last_o == (exp_num == LEN), "R6", "last flag",
                      int'(pix_last_o), int'(exp_num == LEN));
                if (pix_last_o) lasts++;
                exp_num = (exp_num == LEN) ? 1 : exp_num + 1;
            end else begin
                check(pix_tag_o == 2'd0 && !pix_last_o, "R5", "idle tag/last",
                      int'({pix_tag_o, pix_last_o}), 0);
            end
            if (line_start_i) exp_num = 1;
        end
    end

    task automatic send_pair(input int o, input int e, input int gap);
        @(posedge clk); #2;
        odd_valid_i = 1'b1; even_valid_i = 1'b1;
        odd_data_i = DW'(o); even_data_i = DW'(e);
        exp_q.push_back(o & ((1 << DW) - 1));
        exp_q.push_back(e & ((1 << DW) - 1));
        @(posedge clk); #2;
        odd_valid_i = 1'b0; even_valid_i = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2; rst_n = 1'b1;
        exp_q.delete();
    endtask

    task automatic drain();
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending pixels", exp_q.size(), 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!pix_valid_o && !pix_ovf_o, "R1", "in reset",
              int'({pix_valid_o, pix_ovf_o}), 0);
        #2; rst_n = 1'b1;
        @(negedge clk);
        check(!pix_valid_o && !pix_ovf_o, "R1", "after reset",
              int'({pix_valid_o, pix_ovf_o}), 0);

        // R2: cycle-exact odd-then-even
        @(posedge clk); #2;
        odd_valid_i = 1; even_valid_i = 1; odd_data_i = 12'h5A1; even_data_i = 12'h3C2;
        exp_q.push_back(12'h5A1); exp_q.push_back(12'h3C2);
        @(negedge clk);
        check(!pix_valid_o, "R2", "before capture", int'(pix_valid_o), 0);
        @(posedge clk); #2; odd_valid_i = 0; even_valid_i = 0;
        @(negedge clk);
        check(pix_valid_o && pix_data_o == 12'h5A1, "R2", "odd first",
              int'(pix_data_o), 12'h5A1);
        @(negedge clk);
        check(pix_valid_o && pix_data_o == 12'h3C2, "R2", "even second",
              int'(pix_data_o), 12'h3C2);
        @(negedge clk);
        check(!pix_valid_o, "R2", "idle after pair", int'(pix_valid_o), 0);
        drain();

        // R3: lone strobes on either channel
        @(posedge clk); #2; odd_valid_i = 1; odd_data_i = 12'h111;
        @(posedge clk); #2; odd_valid_i = 0; even_valid_i = 1;
        @(posedge clk); #2; even_valid_i = 0;
        repeat (2) begin
            @(negedge clk);
            check(!pix_valid_o, "R3", "lone strobe output", int'(pix_valid_o), 0);
        end

        // R9: restart numbering, then full-rate sweep (R4, R5, R6, R8)
        @(posedge clk); #2; line_start_i = 1;
        @(posedge clk); #2; line_start_i = 0;
        seen = 0; lasts = 0;
        for (int ln = 0; ln < 3; ln++) begin
            for (int k = 1; k <= LEN / 2; k++) begin
                s = ln * 97 + 4 * k;
                send_pair(s + 1, s + 2, 0);
            end
        end
        drain();
        check(seen == 3 * LEN, "R8", "full-rate pixel count", seen, 3 * LEN);
        check(lasts == 3, "R6", "lines ended", lasts, 3);
        check(!pix_ovf_o, "R8", "no overflow at full rate", int'(pix_ovf_o), 0);
        check(exp_num == 1, "R4", "number after three lines", exp_num, 1);

        // R4/R5: reduced-rate sweep, continuing numbering
        for (int k = 1; k <= LEN / 2 + 3; k++) send_pair(k * 5, k * 7, 3);
        drain();

        // R9: restart mid-line, then restart during an odd emission
        @(posedge clk); #2; line_start_i = 1;
        @(posedge clk); #2; line_start_i = 0;
        send_pair(12'h0AB, 12'h0CD, 0);
        line_start_i = 1;
        @(posedge clk); #2; line_start_i = 0;
        @(negedge clk);
        check(pix_valid_o && pix_tag_o == 2'd0, "R9", "renumbered even pixel tag",
              int'(pix_tag_o), 0);
        for (int k = 1; k <= LEN / 2; k++) send_pair(k + 300, k + 400, 1);
        drain();
        check(exp_num == 2, "R9", "number after restart line", exp_num, 2);

        // R7: pair while odd pending is dropped, flag sticks
        @(posedge clk); #2;
        odd_valid_i = 1; even_valid_i = 1; odd_data_i = 12'h777; even_data_i = 12'h888;
        exp_q.push_back(12'h777); exp_q.push_back(12'h888);
        @(posedge clk); #2; odd_data_i = 12'h999; even_data_i = 12'hAAA;
        @(posedge clk); #2; odd_valid_i = 0; even_valid_i = 0;
        @(negedge clk);
        check(pix_ovf_o, "R7", "overflow raised", int'(pix_ovf_o), 1);
        drain();
        send_pair(12'h123, 12'h456, 2);
        drain();
        check(pix_ovf_o, "R7", "overflow sticky", int'(pix_ovf_o), 1);
        do_reset();
        @(negedge clk);
        check(!pix_ovf_o && !pix_valid_o, "R1", "reset clears flag",
              int'({pix_valid_o, pix_ovf_o}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule